// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block holds all the per-interrupt state of a parameterised interrupt controller: an enable bit, a pending bit, an 8-bit priority, an 8-bit CPU target mask and a 2-bit trigger configuration for each line. It also holds one global enable bit, and it presents a read-only word that describes how the controller is built. Software reaches this state through a 32-bit register bus. The bus is addressed by word index, where a word index is the byte offset divided by four. Read data is registered, so it appears one clock after the address is presented.

Enable and pending bits use separate set and clear windows, and both windows use write-one semantics. As a result, software never needs a read-modify-write to change one bit. A rising edge on a hardware interrupt line marks that line pending. The enable, pending, priority and target vectors are driven combinationally to a downstream priority selector. The active status comes from that downstream logic and is only reflected for reading.

Top module: `irq_dist_regs`

## Requirements
- R1: After reset the global enable, all enable, pending, priority, target and configuration state, and bus_rdata read as zero.
- R2: Byte offset 0x000 bit 0 is the global enable. It is writable, it reads back as written, and it drives dist_en_o. All other bits read as zero.
- R3: Byte offset 0x004 reads ((NUM_CPU-1)<<5) | (NUM_IRQ/32-1), which is 0x61 with the default parameters. Writes to this offset do not change it.
- R4: A write to byte offset 0x100+4w ORs the data into enable word w, which covers lines 32w..32w+31 with bit i standing for line 32w+i. A read of this offset returns that word.
- R5: A write to byte offset 0x180+4w clears every enable bit of word w that is written as 1. A read of this offset returns the same enable word.
- R6: Byte offsets 0x200+4w and 0x280+4w set and clear pending bits of word w in the same write-one way. Either offset reads back the pending word.
- R7: Pending bits of lines 0..15 are never changed by the set-pending or clear-pending windows.
- R8: When a hardware line rises, its pending bit is set at the next clock edge. This applies to every line, including lines 0..15. If a clear-pending write hits the same line in the same cycle, the set wins.
- R9: A read of byte offset 0x300+4w returns word w of the irq_active input, with bit i standing for line 32w+i.
- R10: Priority words start at byte offset 0x400+4w. Byte b of the word, at bits 8b+7:8b, is the priority of line 4w+b. Priorities are writable, they read back, and they appear on irq_prio_o.
- R11: Target words start at byte offset 0x800+4w and use the same byte layout as R10. Bytes belonging to lines 0..15 ignore writes and read zero. All other bytes are writable, read back, and appear on irq_tgt_o.
- R12: Configuration words start at byte offset 0xC00+4w. Line 16w+i uses bits 2i+1:2i of the word. The even bits, mask 0x55555555, select an unsupported mode: they ignore writes and read zero.
- R13: A read of any unmapped offset returns zero, and a write to it changes nothing. Unmapped offsets include window words beyond the NUM_IRQ implemented lines and offsets 0x008 and 0xF00.
- R14: bus_rdata updates one clock after the address is presented. When the same cycle also carries a write, the read returns the value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 10 | Word index (byte offset / 4) |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq_in | input | NUM_IRQ | Hardware interrupt lines, rising edge marks pending |
| irq_active | input | NUM_IRQ | Active status from the downstream logic |
| dist_en_o | output | 1 | Global enable |
| irq_en_o | output | NUM_IRQ | Per-line enable |
| irq_pend_o | output | NUM_IRQ | Per-line pending |
| irq_prio_o | output | 8*NUM_IRQ | Per-line priority, line k at bits 8k+7:8k |
| irq_tgt_o | output | 8*NUM_IRQ | Per-line CPU target mask, line k at bits 8k+7:8k |

## Verification
A corrupted enable, pending, priority or target bit appears on the matching combinational output in the cycle after the faulty update. A read of the word that holds it shows the same fault one cycle after the address is presented. A wrong decode tends to show first as stray data on reads of unmapped or out-of-range words. It can also show as a change to a protected field, such as a low-line pending bit, a low-line target byte or an unsupported configuration bit, which the next read of that word exposes. A lost hardware edge is visible on irq_pend_o one cycle after the line rises.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_TYPE,
        SEL_EN_SET,
        SEL_EN_CLR,
        SEL_PD_SET,
        SEL_PD_CLR,
        SEL_ACTIVE,
        SEL_PRIO,
        SEL_TGT,
        SEL_CFG
    } reg_sel_e;

    localparam int unsigned FIELD_W    = 8;
    localparam int unsigned LOW_LINES  = 16;
    localparam logic [31:0] MODE_BITS  = 32'h5555_5555;

endpackage

// File: rtl/irq_edge_rise.sv
module irq_edge_rise #(
    parameter int unsigned W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
endmodule

// File: rtl/irq_dist_decode.sv
module irq_dist_decode
    import irq_dist_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 64
) (
    input  logic [9:0] addr,
    output reg_sel_e   sel,
    output logic [7:0] widx
);
    localparam int unsigned BIT_WORDS  = NUM_IRQ / 32;
    localparam int unsigned BYTE_WORDS = NUM_IRQ / 4;
    localparam int unsigned CFG_WORDS  = NUM_IRQ / 16;

    always_comb begin
        sel  = SEL_NONE;
        widx = '0;
        if (addr == 10'd0) begin
            sel = SEL_CTRL;
        end else if (addr == 10'd1) begin
            sel = SEL_TYPE;
        end else if (addr[9:8] == 2'b00 && addr[7:5] >= 3'd2 && addr[7:5] <= 3'd6) begin
            widx = {3'b000, addr[4:0]};
            if (int'(addr[4:0]) < BIT_WORDS) begin
                case (addr[7:5])
                    3'd2:    sel = SEL_EN_SET;
                    3'd3:    sel = SEL_EN_CLR;
                    3'd4:    sel = SEL_PD_SET;
                    3'd5:    sel = SEL_PD_CLR;
                    default: sel = SEL_ACTIVE;
                endcase
            end
        end else if (addr[9:8] == 2'b01 || addr[9:8] == 2'b10) begin
            widx = addr[7:0];
            if (int'(addr[7:0]) < BYTE_WORDS)
                sel = (addr[9:8] == 2'b01) ? SEL_PRIO : SEL_TGT;
        end else if (addr[9:6] == 4'hC) begin
            widx = {2'b00, addr[5:0]};
            if (int'(addr[5:0]) < CFG_WORDS) sel = SEL_CFG;
        end
    end
endmodule

// File: rtl/irq_dist_regs.sv
module irq_dist_regs
    import irq_dist_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 64,
    parameter int unsigned NUM_CPU = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [9:0]                 bus_addr,
    input  logic                       bus_we,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    input  logic [NUM_IRQ-1:0]         irq_in,
    input  logic [NUM_IRQ-1:0]         irq_active,
    output logic                       dist_en_o,
    output logic [NUM_IRQ-1:0]         irq_en_o,
    output logic [NUM_IRQ-1:0]         irq_pend_o,
    output logic [FIELD_W*NUM_IRQ-1:0] irq_prio_o,
    output logic [FIELD_W*NUM_IRQ-1:0] irq_tgt_o
);
    localparam int unsigned BYTE_BITS = FIELD_W * NUM_IRQ;
    localparam int unsigned CFG_BITS  = 2 * NUM_IRQ;
    localparam logic [31:0] TYPE_WORD = 32'(((NUM_CPU - 1) << 5) | (NUM_IRQ / 32 - 1));

    typedef struct packed {
        logic                 glob_en;
        logic [NUM_IRQ-1:0]   en;
        logic [NUM_IRQ-1:0]   pend;
        logic [BYTE_BITS-1:0] prio;
        logic [BYTE_BITS-1:0] tgt;
        logic [CFG_BITS-1:0]  cfg;
        logic [31:0]          rdata;
    } bank_t;

    bank_t        st_d, st_q;
    reg_sel_e     sel;
    logic [7:0]   widx;
    logic [NUM_IRQ-1:0] rise;

    irq_dist_decode #(.NUM_IRQ(NUM_IRQ)) u_decode (
        .addr (bus_addr),
        .sel  (sel),
        .widx (widx)
    );

    irq_edge_rise #(.W(NUM_IRQ)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (irq_in),
        .rise  (rise)
    );

    always_comb begin
        int w;
        w    = int'(widx);
        st_d = st_q;

        // read path: value before any write of this cycle
        case (sel)
            SEL_CTRL:                st_d.rdata = {31'b0, st_q.glob_en};
            SEL_TYPE:                st_d.rdata = TYPE_WORD;
            SEL_EN_SET, SEL_EN_CLR:  st_d.rdata = st_q.en[w*32 +: 32];
            SEL_PD_SET, SEL_PD_CLR:  st_d.rdata = st_q.pend[w*32 +: 32];
            SEL_ACTIVE:              st_d.rdata = irq_active[w*32 +: 32];
            SEL_PRIO:                st_d.rdata = st_q.prio[w*32 +: 32];
            SEL_TGT:                 st_d.rdata = st_q.tgt[w*32 +: 32];
            SEL_CFG:                 st_d.rdata = st_q.cfg[w*32 +: 32];
            default:                 st_d.rdata = '0;
        endcase

        if (bus_we) begin
            case (sel)
                SEL_CTRL:   st_d.glob_en = bus_wdata[0];
                SEL_EN_SET: st_d.en[w*32 +: 32] = st_q.en[w*32 +: 32] | bus_wdata;
                SEL_EN_CLR: st_d.en[w*32 +: 32] = st_q.en[w*32 +: 32] & ~bus_wdata;
                SEL_PD_SET: st_d.pend[w*32 +: 32] = st_q.pend[w*32 +: 32] | bus_wdata;
                SEL_PD_CLR: st_d.pend[w*32 +: 32] = st_q.pend[w*32 +: 32] & ~bus_wdata;
                SEL_PRIO:   st_d.prio[w*32 +: 32] = bus_wdata;
                SEL_TGT: begin
                    for (int b = 0; b < 4; b++) begin
                        if (w * 4 + b >= int'(LOW_LINES))
                            st_d.tgt[(w*4+b)*FIELD_W +: FIELD_W] = bus_wdata[b*8 +: 8];
                    end
                end
                SEL_CFG:    st_d.cfg[w*32 +: 32] = bus_wdata & ~MODE_BITS;
                default:    ;
            endcase
            // low lines are out of reach of the pending windows
            st_d.pend[LOW_LINES-1:0] = st_q.pend[LOW_LINES-1:0];
        end

        // hardware edges win over a clear in the same cycle
        st_d.pend = st_d.pend | rise;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata  = st_q.rdata;
    assign dist_en_o  = st_q.glob_en;
    assign irq_en_o   = st_q.en;
    assign irq_pend_o = st_q.pend;
    assign irq_prio_o = st_q.prio;
    assign irq_tgt_o  = st_q.tgt;
endmodule

// File: rtl/irq_dist_regs_chk.sv
module irq_dist_regs_chk #(
    parameter int unsigned NUM_IRQ = 64,
    parameter int unsigned NUM_CPU = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic [9:0]   bus_addr,
    input logic         bus_we,
    input logic [31:0]  bus_wdata,
    input logic [31:0]  bus_rdata,
    input logic [15:0]  irq_low,
    input logic [31:0]  en_w0,
    input logic [15:0]  pend_low,
    input logic [127:0] tgt_low
);
    localparam logic [31:0] TYPE_WORD = 32'(((NUM_CPU - 1) << 5) | (NUM_IRQ / 32 - 1));

    assert_en_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 10'h040) |=> ((en_w0 & $past(bus_wdata)) == $past(bus_wdata)));

    assert_en_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 10'h060) |=> ((en_w0 & $past(bus_wdata)) == 32'h0));

    assert_low_pend_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pend_low) & ~pend_low) == 16'h0));

    assert_low_pend_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_low & ~$past(pend_low) & ~$past(irq_low)) == 16'h0));

    assert_edge_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_low[0]) |=> pend_low[0]);

    assert_type_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 10'h001) |=> (bus_rdata == TYPE_WORD));

    assert_low_tgt_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(tgt_low));

    assert_unmapped_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[9:6] == 4'hF) |=> (bus_rdata == 32'h0));
endmodule

bind irq_dist_regs irq_dist_regs_chk #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_low   (irq_in[15:0]),
    .en_w0     (irq_en_o[31:0]),
    .pend_low  (irq_pend_o[15:0]),
    .tgt_low   (irq_tgt_o[127:0])
);

// File: tb/irq_dist_regs_bench.sv
`timescale 1ns/1ps
module irq_dist_regs_bench;
    localparam int unsigned N = 64;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [9:0]     bus_addr = '0;
    logic           bus_we = 1'b0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [N-1:0]   irq_in = '0;
    logic [N-1:0]   irq_active = '0;
    logic           dist_en_o;
    logic [N-1:0]   irq_en_o;
    logic [N-1:0]   irq_pend_o;
    logic [8*N-1:0] irq_prio_o;
    logic [8*N-1:0] irq_tgt_o;

    always #4 clk = ~clk;

    irq_dist_regs #(.NUM_IRQ(N), .NUM_CPU(4)) u_irq_dist_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .irq_active(irq_active), .dist_en_o(dist_en_o), .irq_en_o(irq_en_o),
        .irq_pend_o(irq_pend_o), .irq_prio_o(irq_prio_o), .irq_tgt_o(irq_tgt_o)
    );

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    int    n_chk = 0;
    int    n_fail = 0;
    logic  issue = 1'b0;
    logic  armed = 1'b0;
    logic  done = 1'b0;

    always @(posedge clk) armed <= issue;

    // monitor: compares registered read data against the scoreboard
    always @(negedge clk) begin
        if (armed) begin
            n_chk++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard underflow: actual %h expected none", bus_rdata);
            end else begin
                item_t it;
                it = sb.pop_front();
                if (bus_rdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] off, input logic [31:0] d);
        @(negedge clk);
        bus_addr = off[11:2]; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rw(input logic [11:0] off, input logic we, input logic [31:0] d,
                      input logic [31:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        bus_addr = off[11:2]; bus_wdata = d; bus_we = we;
        it.exp = exp; it.tag = tag;
        sb.push_back(it);
        issue = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; issue = 1'b0;
    endtask

    task automatic rd(input logic [11:0] off, input logic [31:0] exp, input string tag);
        rw(off, 1'b0, 32'h0, exp, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(64'(bus_rdata), 64'h0, "R1 rdata");
        chk(64'(dist_en_o), 64'h0, "R1 dist_en");
        chk(irq_en_o | irq_pend_o, 64'h0, "R1 en/pend");
        rd(12'h100, 32'h0, "R1 enable word");
        rd(12'h810, 32'h0, "R1 target word");

        wr(12'h000, 32'h1);
        chk(64'(dist_en_o), 64'h1, "R2 enable out");
        rd(12'h000, 32'h1, "R2 readback");
        wr(12'h000, 32'hFFFF_FFFE);
        rd(12'h000, 32'h0, "R2 cleared");

        rd(12'h004, 32'h61, "R3 type");
        wr(12'h004, 32'h0000_FFFF);
        rd(12'h004, 32'h61, "R3 type after write");

        wr(12'h100, 32'h0000_F00F);
        wr(12'h104, 32'h8000_0000);
        rd(12'h100, 32'h0000_F00F, "R4 set word0");
        chk(64'(irq_en_o[63]), 64'h1, "R4 line 63");
        wr(12'h180, 32'h3);
        rd(12'h180, 32'h0000_F00C, "R5 clear read");
        rd(12'h100, 32'h0000_F00C, "R5 via set window");
        wr(12'h184, 32'hFFFF_FFFF);
        rd(12'h104, 32'h0, "R5 word1 cleared");

        @(negedge clk);
        irq_in[3] = 1'b1; irq_in[20] = 1'b1;
        @(negedge clk);
        chk(64'({irq_pend_o[20], irq_pend_o[3]}), 64'h3, "R8 edges");
        wr(12'h280, 32'hFFFF_FFFF);
        rd(12'h200, 32'h0000_0008, "R7 low bit kept on clear");
        wr(12'h200, 32'hFFFF_FFFF);
        rd(12'h280, 32'hFFFF_0008, "R7 low bits untouched by set");
        wr(12'h280, 32'hFFFF_FFFF);
        rd(12'h200, 32'h0000_0008, "R6 clear pending");
        wr(12'h204, 32'h0000_0100);
        rd(12'h204, 32'h0000_0100, "R6 set pending word1");
        wr(12'h284, 32'h0000_0100);
        rd(12'h204, 32'h0, "R6 cleared word1");
        @(negedge clk);
        bus_addr = 10'(12'h284 >> 2); bus_wdata = 32'h0000_0100; bus_we = 1'b1;
        irq_in[40] = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        chk(64'(irq_pend_o[40]), 64'h1, "R8 edge beats clear");

        irq_active = 64'hDEAD_BEEF_0123_4567;
        rd(12'h300, 32'h0123_4567, "R9 active word0");
        rd(12'h304, 32'hDEAD_BEEF, "R9 active word1");

        wr(12'h40C, 32'hA1B2_C3D4);
        chk(64'(irq_prio_o[12*8 +: 8]), 64'hD4, "R10 line 12");
        chk(64'(irq_prio_o[15*8 +: 8]), 64'hA1, "R10 line 15");
        rd(12'h40C, 32'hA1B2_C3D4, "R10 readback");
        rd(12'h400, 32'h0, "R10 other word");

        wr(12'h800, 32'hFFFF_FFFF);
        wr(12'h80C, 32'hFFFF_FFFF);
        rd(12'h800, 32'h0, "R11 low word0");
        rd(12'h80C, 32'h0, "R11 low word3");
        wr(12'h810, 32'h0403_0201);
        rd(12'h810, 32'h0403_0201, "R11 line16 word");
        chk(64'(irq_tgt_o[17*8 +: 8]), 64'h02, "R11 line 17 out");

        wr(12'hC04, 32'hFFFF_FFFF);
        rd(12'hC04, 32'hAAAA_AAAA, "R12 mode bits dropped");
        wr(12'hC04, 32'h5555_5555);
        rd(12'hC04, 32'h0, "R12 only mode bits");

        rd(12'hF00, 32'h0, "R13 0xF00");
        rd(12'h008, 32'h0, "R13 0x008");
        wr(12'h108, 32'hFFFF_FFFF);
        rd(12'h108, 32'h0, "R13 beyond lines");
        rd(12'h100, 32'h0000_F00C, "R13 enable intact");
        wr(12'h500, 32'h1234_5678);
        rd(12'h500, 32'h0, "R13 prio beyond lines");
        wr(12'hC10, 32'hFFFF_FFFF);
        rd(12'hC10, 32'h0, "R13 cfg beyond lines");

        rw(12'h104, 1'b1, 32'h1, 32'h0, "R14 old value on write");
        rd(12'h104, 32'h1, "R14 new value next");

        repeat (3) @(negedge clk);
        chk(64'(sb.size()), 64'h0, "R14 scoreboard drained");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule